// File: doc/BRIEF.md
# Infrared SIR Pulse Encoder

This block turns the serial output of a UART into the narrow-pulse stream used by low-rate serial infrared links. It runs from a clock at sixteen times the baud rate and treats every bit the same way, whether start, data or stop. A bit that is low produces one short pulse in its bit period. A bit that is high produces no pulse. The output feeds an external LED driver stage.

A phase counter counts falling clock edges while the serial line is low. It is held at zero whenever the line is high, so each run of low bits starts from a known phase. The output register goes high for a fixed window of edges inside each bit period. With the default parameters this window is three clocks wide, starting after the seventh edge and ending after the tenth. All state changes on the falling edge of the clock, and the synchronous active-high reset is sampled on that same edge.

Top module: `sir_pulse_encoder`

## Requirements
- R1: After a falling clock edge with reset high, the infrared output is low.
- R2: At every falling edge where the serial input is high, the output goes low and the phase is cleared. The next low bit then counts its edges from 1 again.
- R3: The first falling edge that samples the serial input low is edge 1. The output rises after edge 7 (the window start, parameter PULSE_START = 7).
- R4: The output falls after edge 10, so each pulse is exactly 3 clocks (PULSE_LEN) wide.
- R5: While the input stays low, the phase wraps from 15 to 0 (OVERSAMPLE = 16). Pulses therefore repeat every 16 edges, rising after edges 7, 23, 39 and so on.
- R6: A high bit of 16 edges placed between low bits produces no pulse, and the following low bit pulses after its own seventh edge.
- R7: If the input returns high while a pulse is in progress, the output is low after that same edge.
- R8: A reset applied while the line is low ends any pulse. Once reset is released with the line still low, counting restarts at edge 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_16x_i | input | 1 | Clock at 16 times the baud rate; state changes on its falling edge |
| rst_i | input | 1 | Synchronous active-high reset, sampled on the falling edge |
| uart_tx_i | input | 1 | Serial line from the UART transmitter, idle high |
| ir_pulse_o | output | 1 | Registered pulse stream to the LED driver, active high |

## Verification
Every result appears one falling edge after the edge that samples the input: the output register takes the next phase and the input in the same cycle. The bench changes the input on the rising edge. It then compares the output at the next rising edge, which is half a cycle after the only falling edge that could have acted on that input. The bench's expected value is a count of low edges since the last high or reset sample, taken modulo 16. Directed runs count rising edges after the line falls and confirm the rise after edge 7, the fall after edge 10 and the next rise after edge 23.

// File: rtl/sir_enc_pkg.sv
`timescale 1ns/1ps
package sir_enc_pkg;

  // Default framing of the encoder: samples per bit and pulse window.
  localparam int DEF_OVERSAMPLE  = 16;
  localparam int DEF_PULSE_START = 7;
  localparam int DEF_PULSE_LEN   = 3;

  // Phase state of the pulse former.
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_COUNT = 2'd1,
    PH_PULSE = 2'd2
  } sir_phase_e;

endpackage

// File: rtl/sir_phase_counter.sv
`timescale 1ns/1ps
module sir_phase_counter #(
  parameter int OVERSAMPLE = sir_enc_pkg::DEF_OVERSAMPLE,
  localparam int CW        = $clog2(OVERSAMPLE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_idle,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_d
);

  localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

  logic [CW-1:0] cnt_inc;

  // A power-of-two period wraps naturally; any other period compares.
  generate
    if ((1 << CW) == OVERSAMPLE) begin : g_pow2
      assign cnt_inc = cnt_q + CW'(1);
    end else begin : g_mod
      assign cnt_inc = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
    end
  endgenerate

  assign cnt_d = (rst || line_idle) ? '0 : cnt_inc;

  always_ff @(negedge clk) begin
    cnt_q <= cnt_d;
  end

  // R2: high line clears the phase
  assert_clear_on_idle_R2: assert property (@(negedge clk) disable iff (rst)
    line_idle |=> (cnt_q == '0));

  // R5: wrap back to zero at the end of a bit period
  assert_wrap_R5: assert property (@(negedge clk) disable iff (rst)
    (!line_idle && cnt_q == LAST) |=> (cnt_q == '0));

  // R3: phase advances by one per low edge
  assert_step_R3: assert property (@(negedge clk) disable iff (rst)
    (!line_idle && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + CW'(1)));

endmodule

// File: rtl/sir_pulse_window.sv
`timescale 1ns/1ps
module sir_pulse_window #(
  parameter int OVERSAMPLE  = sir_enc_pkg::DEF_OVERSAMPLE,
  parameter int PULSE_START = sir_enc_pkg::DEF_PULSE_START,
  parameter int PULSE_LEN   = sir_enc_pkg::DEF_PULSE_LEN,
  localparam int CW         = $clog2(OVERSAMPLE)
) (
  input  logic [CW-1:0] phase,
  output logic          hit
);

  localparam logic [CW-1:0] FIRST = CW'(PULSE_START);
  localparam logic [CW-1:0] FINAL = CW'(PULSE_START + PULSE_LEN - 1);

  // Phase here is the value after the coming edge: edge k leaves phase k.
  assign hit = (phase >= FIRST) && (phase <= FINAL);

endmodule

// File: rtl/sir_tx_outreg.sv
`timescale 1ns/1ps
module sir_tx_outreg (
  input  logic clk,
  input  logic rst,
  input  logic line_idle,
  input  logic hit,
  output logic pulse_q
);

  always_ff @(negedge clk) begin
    if (rst || line_idle) pulse_q <= 1'b0;
    else                  pulse_q <= hit;
  end

  // R7: a pulse never survives an edge that sees the line high
  assert_abort_R7: assert property (@(negedge clk) disable iff (rst)
    (pulse_q && line_idle) |=> !pulse_q);

endmodule

// File: rtl/sir_pulse_encoder.sv
`timescale 1ns/1ps
module sir_pulse_encoder #(
  parameter int OVERSAMPLE  = sir_enc_pkg::DEF_OVERSAMPLE,
  parameter int PULSE_START = sir_enc_pkg::DEF_PULSE_START,
  parameter int PULSE_LEN   = sir_enc_pkg::DEF_PULSE_LEN
) (
  input  logic clk_16x_i,
  input  logic rst_i,
  input  logic uart_tx_i,
  output logic ir_pulse_o
);

  localparam int CW = $clog2(OVERSAMPLE);
  localparam logic [CW-1:0] FIRST = CW'(PULSE_START);
  localparam logic [CW-1:0] FINAL = CW'(PULSE_START + PULSE_LEN - 1);

  logic          line_idle;
  logic [CW-1:0] phase_q;
  logic [CW-1:0] phase_d;
  logic          in_window;
  logic          pulse_q;

  assign line_idle = uart_tx_i;

  sir_phase_counter #(.OVERSAMPLE(OVERSAMPLE)) u_phase (
    .clk       (clk_16x_i),
    .rst       (rst_i),
    .line_idle (line_idle),
    .cnt_q     (phase_q),
    .cnt_d     (phase_d)
  );

  sir_pulse_window #(
    .OVERSAMPLE  (OVERSAMPLE),
    .PULSE_START (PULSE_START),
    .PULSE_LEN   (PULSE_LEN)
  ) u_window (
    .phase (phase_d),
    .hit   (in_window)
  );

  sir_tx_outreg u_out (
    .clk       (clk_16x_i),
    .rst       (rst_i),
    .line_idle (line_idle),
    .hit       (in_window),
    .pulse_q   (pulse_q)
  );

  assign ir_pulse_o = pulse_q;

  // R1 / R8: reset always leaves the output dark
  assert_reset_dark_R1: assert property (@(negedge clk_16x_i)
    rst_i |=> !ir_pulse_o);

  // R2: a high serial line leaves the output low
  assert_idle_dark_R2: assert property (@(negedge clk_16x_i) disable iff (rst_i)
    uart_tx_i |=> !ir_pulse_o);

  // R4: output high only while the stored phase sits in the window
  assert_window_R4: assert property (@(negedge clk_16x_i) disable iff (rst_i)
    ir_pulse_o |-> (phase_q >= FIRST && phase_q <= FINAL));

  // R4: a pulse is never a single clock wide
  assert_min_width_R4: assert property (@(negedge clk_16x_i) disable iff (rst_i)
    ($rose(ir_pulse_o) && !uart_tx_i) |=> ir_pulse_o);

endmodule

// File: tb/sir_pulse_encoder_tb.sv
`timescale 1ns/1ps
module sir_pulse_encoder_tb;

  localparam int OS    = 16;
  localparam int START = 7;
  localparam int LEN   = 3;
  localparam int NVEC  = 11;

  // {rst[15], ser[14], tag[13:8], cycles[7:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 6'd2, 8'd4},
    {1'b0, 1'b0, 6'd3, 8'd16},
    {1'b0, 1'b1, 6'd6, 8'd16},
    {1'b0, 1'b0, 6'd5, 8'd48},
    {1'b0, 1'b1, 6'd2, 8'd8},
    {1'b0, 1'b0, 6'd7, 8'd8},
    {1'b0, 1'b1, 6'd7, 8'd4},
    {1'b0, 1'b0, 6'd4, 8'd9},
    {1'b1, 1'b0, 6'd8, 8'd3},
    {1'b0, 1'b0, 6'd8, 8'd20},
    {1'b0, 1'b1, 6'd2, 8'd5}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser = 1'b1;
  logic ir;

  int    checks = 0;
  int    fails  = 0;
  int    phase  = 0;
  logic  exp_ir = 1'b0;
  string last_tag = "R1";

  always #2.5 clk = ~clk;

  sir_pulse_encoder u_dut (
    .clk_16x_i  (clk),
    .rst_i      (rst),
    .uart_tx_i  (ser),
    .ir_pulse_o (ir)
  );

  function automatic string tag_name(int i);
    case (i)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check_val(int act, int expv, string tag);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  // Compare the result of the previous drive, then drive the next value.
  task automatic step(logic s, logic r, string tag);
    @(posedge clk);
    check_val(int'(ir), int'(exp_ir), last_tag);
    ser = s;
    rst = r;
    last_tag = tag;
    if (r || s) begin
      phase  = 0;
      exp_ir = 1'b0;
    end else begin
      phase  = (phase + 1) % OS;
      exp_ir = (phase >= START) && (phase < START + LEN);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int first_rise;
    int first_fall;
    int second_rise;
    logic prev;

    repeat (3) @(posedge clk);
    // R1: reset state
    check_val(int'(ir), 0, "R1");

    for (int v = 0; v < NVEC; v++) begin
      for (int c = 0; c < int'(VEC[v][7:0]); c++) begin
        step(VEC[v][14], VEC[v][15], tag_name(int'(VEC[v][13:8])));
      end
    end
    step(1'b1, 1'b0, "R2");
    step(1'b1, 1'b0, "R2");

    // Directed: edge positions of the pulses on a long low run
    first_rise  = -1;
    first_fall  = -1;
    second_rise = -1;
    @(posedge clk);
    ser  = 1'b0;
    prev = 1'b0;
    for (int e = 1; e <= 40; e++) begin
      @(posedge clk);
      if (ir && !prev) begin
        if (first_rise < 0) first_rise = e;
        else if (second_rise < 0) second_rise = e;
      end
      if (!ir && prev && first_fall < 0) first_fall = e;
      prev = ir;
    end
    check_val(first_rise, 7, "R3");
    check_val(first_fall, 10, "R4");
    check_val(first_fall - first_rise, LEN, "R4");
    check_val(second_rise, 23, "R5");

    // Directed: reset lands inside a pulse (R8)
    @(posedge clk);
    ser = 1'b1;
    @(posedge clk);
    ser = 1'b0;
    repeat (8) @(posedge clk);
    check_val(int'(ir), 1, "R8");
    rst = 1'b1;
    @(posedge clk);
    check_val(int'(ir), 0, "R8");
    rst = 1'b0;
    repeat (6) @(posedge clk);
    check_val(int'(ir), 0, "R8");
    @(posedge clk);
    check_val(int'(ir), 1, "R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule